// File: doc/BRIEF.md
# Endpoint STALL Handshake Manager

This block decides, for a group of device endpoints, whether each incoming token is answered normally or refused with a STALL handshake. Software controls a per-endpoint stall request through two one-cycle strobes: one arms the request and one removes it. While the request is armed, every token addressed to that endpoint is refused with STALL. The reply also tells the transfer logic not to raise its data-received or data-sent flags, so the refused packet leaves no trace in the data path.

Control endpoints follow one extra rule. A SETUP token is always accepted, and it drops any pending stall request in the cycle it arrives, so the host can always recover the endpoint with a fresh control transfer. Each STALL actually sent sets a sticky per-endpoint flag. Software clears that flag by writing one to it. When enabled, the flag drives the endpoint's interrupt line.

A token is sampled on the clock edge. Its reply appears on the registered outputs after that edge, and the stall and flag state is updated at the same edge.

Top module: `ep_stall_mgr`

## Requirements
- R1: After reset, all stall requests, all stalled flags and all interrupt lines are 0, and `hs_valid` is 0.
- R2: A pulse on `stall_set[e]` makes `stall_req[e]` 1 after the edge. From then on, every valid token to endpoint e gets `hs_code`=2 (STALL) on the cycle after the token, except a SETUP on a control endpoint.
- R3: Whenever the reply is STALL, `rx_ok` and `tx_ok` are both 0.
- R4: A SETUP token (`tok_type`=2) to an endpoint with `ep_is_ctrl[e]`=1 is answered with `hs_code`=1 (ACK) and `rx_ok`=1, even if stall is requested. It clears `stall_req[e]` at the same edge.
- R5: A SETUP token to a non-control endpoint with stall requested is answered with STALL, and the stall request stays set.
- R6: A pulse on `stall_clr[e]` clears `stall_req[e]` for both endpoint types.
- R7: If `stall_set[e]` and `stall_clr[e]` pulse in the same cycle, `stall_req[e]` ends up 0.
- R8: Each STALL sent to endpoint e sets `stalled[e]`, and the flag stays set until a pulse on `stalled_clr[e]` clears it. If a STALL and a clear hit the same endpoint in one cycle, the flag ends up 1.
- R9: `ep_irq[e]` is a registered copy of the new `stalled[e]` ANDed with `stalled_ie[e]` as sampled at the same edge.
- R10: With no stall requested, OUT (`tok_type`=0) and SETUP are answered ACK with `rx_ok`=1, `tx_ok`=0, and IN (`tok_type`=1) is answered ACK with `tx_ok`=1, `rx_ok`=0.
- R11: A token of the reserved type 3 gives `hs_valid`=0 and changes no stall request.
- R12: Strobes and tokens for one endpoint leave the stall request of every other endpoint unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | A token is present this cycle |
| tok_type | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 reserved |
| tok_ep | input | EPW | Endpoint addressed by the token |
| ep_is_ctrl | input | N_EP | Per-endpoint control-type indication |
| stall_set | input | N_EP | Per-endpoint stall-request set strobe |
| stall_clr | input | N_EP | Per-endpoint stall-request clear strobe |
| stalled_clr | input | N_EP | Write-one-to-clear strobe for the stalled flag |
| stalled_ie | input | N_EP | Interrupt enable for the stalled flag |
| hs_valid | output | 1 | A reply is presented this cycle |
| hs_code | output | 2 | Reply: 0 none, 1 ACK, 2 STALL |
| hs_ep | output | EPW | Endpoint the reply belongs to |
| rx_ok | output | 1 | Data-received flag may be raised |
| tx_ok | output | 1 | Data-sent flag may be raised |
| stall_req | output | N_EP | Current stall requests |
| stalled | output | N_EP | Sticky STALL-sent flags |
| ep_irq | output | N_EP | Per-endpoint interrupt |

## Verification
The bench builds the block with N_EP=4, so EPW=2, and marks endpoints 0 and 2 as control endpoints. Every value of `tok_ep` therefore addresses a real endpoint. Both endpoint types are present together, which makes it possible to test the SETUP recovery rule against its non-control counterpart. It also allows checking that a strobe on one endpoint leaves its neighbours unchanged.

// File: rtl/ep_stall_pkg.sv
package ep_stall_pkg;
  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  typedef struct packed {
    logic valid;
    hs_e  code;
    logic rx_ok;
    logic tx_ok;
  } resp_t;
endpackage

// File: rtl/ep_tok_decode.sv
module ep_tok_decode
  import ep_stall_pkg::*;
#(
  parameter int N_EP = 4,
  parameter int EPW  = 2
) (
  input  logic            tok_valid,
  input  logic [1:0]      tok_type,
  input  logic [EPW-1:0]  tok_ep,
  input  logic [N_EP-1:0] ep_is_ctrl,
  input  logic [N_EP-1:0] stall_q,
  output logic [N_EP-1:0] setup_drop,
  output logic [N_EP-1:0] stall_sent,
  output resp_t           resp_d
);
  logic            addr_ok;
  logic [N_EP-1:0] hit;
  logic            cur_stall;
  logic            cur_ctrl;
  logic            is_setup;

  assign addr_ok  = tok_valid && (tok_type != TOK_RSVD) && (32'(tok_ep) < N_EP);
  assign is_setup = (tok_type == TOK_SETUP);

  for (genvar i = 0; i < N_EP; i++) begin : g_hit
    assign hit[i]        = addr_ok && (tok_ep == EPW'(i));
    assign setup_drop[i] = hit[i] && is_setup && ep_is_ctrl[i];
    assign stall_sent[i] = hit[i] && stall_q[i] && !setup_drop[i];
  end

  assign cur_stall = |(hit & stall_q);
  assign cur_ctrl  = |(hit & ep_is_ctrl);

  always_comb begin
    resp_d       = '0;
    resp_d.code  = HS_NONE;
    resp_d.valid = addr_ok;
    if (addr_ok) begin
      if (is_setup && cur_ctrl) begin
        resp_d.code  = HS_ACK;
        resp_d.rx_ok = 1'b1;
      end else if (cur_stall) begin
        resp_d.code  = HS_STALL;
      end else begin
        resp_d.code  = HS_ACK;
        resp_d.rx_ok = (tok_type != TOK_IN);
        resp_d.tx_ok = (tok_type == TOK_IN);
      end
    end
  end
endmodule

// File: rtl/ep_stall_cell.sv
module ep_stall_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic setup_drop,
  input  logic stall_sent,
  input  logic flag_clr,
  input  logic irq_en,
  output logic stall_q,
  output logic flag_q,
  output logic irq_q
);
  logic flag_d;

  // a new STALL outranks a software clear of the same flag
  assign flag_d = stall_sent | (flag_q & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (clr_stb || setup_drop) stall_q <= 1'b0;
      else if (set_stb)          stall_q <= 1'b1;
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en;
    end
  end
endmodule

// File: rtl/ep_resp_reg.sv
module ep_resp_reg
  import ep_stall_pkg::*;
#(
  parameter int EPW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  resp_t          resp_d,
  input  logic [EPW-1:0] ep_d,
  output resp_t          resp_q,
  output logic [EPW-1:0] ep_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q <= '0;
      ep_q   <= '0;
    end else begin
      resp_q <= resp_d;
      ep_q   <= ep_d;
    end
  end
endmodule

// File: rtl/ep_stall_mgr.sv
module ep_stall_mgr
  import ep_stall_pkg::*;
#(
  parameter int N_EP = 4,
  localparam int EPW = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tok_valid,
  input  logic [1:0]      tok_type,
  input  logic [EPW-1:0]  tok_ep,
  input  logic [N_EP-1:0] ep_is_ctrl,
  input  logic [N_EP-1:0] stall_set,
  input  logic [N_EP-1:0] stall_clr,
  input  logic [N_EP-1:0] stalled_clr,
  input  logic [N_EP-1:0] stalled_ie,
  output logic            hs_valid,
  output logic [1:0]      hs_code,
  output logic [EPW-1:0]  hs_ep,
  output logic            rx_ok,
  output logic            tx_ok,
  output logic [N_EP-1:0] stall_req,
  output logic [N_EP-1:0] stalled,
  output logic [N_EP-1:0] ep_irq
);
  logic [N_EP-1:0] setup_drop;
  logic [N_EP-1:0] stall_sent;
  resp_t           resp_d;
  resp_t           resp_q;

  ep_tok_decode #(.N_EP(N_EP), .EPW(EPW)) u_dec (
    .tok_valid  (tok_valid),
    .tok_type   (tok_type),
    .tok_ep     (tok_ep),
    .ep_is_ctrl (ep_is_ctrl),
    .stall_q    (stall_req),
    .setup_drop (setup_drop),
    .stall_sent (stall_sent),
    .resp_d     (resp_d)
  );

  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    ep_stall_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .set_stb    (stall_set[i]),
      .clr_stb    (stall_clr[i]),
      .setup_drop (setup_drop[i]),
      .stall_sent (stall_sent[i]),
      .flag_clr   (stalled_clr[i]),
      .irq_en     (stalled_ie[i]),
      .stall_q    (stall_req[i]),
      .flag_q     (stalled[i]),
      .irq_q      (ep_irq[i])
    );
  end

  ep_resp_reg #(.EPW(EPW)) u_resp (
    .clk    (clk),
    .rst    (rst),
    .resp_d (resp_d),
    .ep_d   (tok_ep),
    .resp_q (resp_q),
    .ep_q   (hs_ep)
  );

  assign hs_valid = resp_q.valid;
  assign hs_code  = resp_q.code;
  assign rx_ok    = resp_q.rx_ok;
  assign tx_ok    = resp_q.tx_ok;
endmodule

// File: rtl/ep_stall_mgr_chk.sv
module ep_stall_mgr_chk #(
  parameter int N_EP = 4,
  localparam int EPW = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            tok_valid,
  input logic [1:0]      tok_type,
  input logic [EPW-1:0]  tok_ep,
  input logic [N_EP-1:0] ep_is_ctrl,
  input logic [N_EP-1:0] stall_set,
  input logic [N_EP-1:0] stall_clr,
  input logic [N_EP-1:0] stalled_clr,
  input logic [N_EP-1:0] stalled_ie,
  input logic            hs_valid,
  input logic [1:0]      hs_code,
  input logic [EPW-1:0]  hs_ep,
  input logic            rx_ok,
  input logic            tx_ok,
  input logic [N_EP-1:0] stall_req,
  input logic [N_EP-1:0] stalled,
  input logic [N_EP-1:0] ep_irq
);
  logic in_rng;
  logic ctrl_setup;
  assign in_rng     = tok_valid && (32'(tok_ep) < N_EP);
  assign ctrl_setup = in_rng && (tok_type == 2'd2) && ep_is_ctrl[tok_ep];

  // R2
  a_r2_stall_reply: assert property (@(posedge clk) disable iff (rst)
    in_rng && (tok_type != 2'd3) && stall_req[tok_ep] && !ctrl_setup
    |=> hs_valid && (hs_code == 2'd2));

  // R3
  a_r3_stall_no_flags: assert property (@(posedge clk) disable iff (rst)
    hs_valid && (hs_code == 2'd2) |-> !rx_ok && !tx_ok);

  // R4
  a_r4_setup_ack: assert property (@(posedge clk) disable iff (rst)
    ctrl_setup |=> (hs_code == 2'd1) && rx_ok && !stall_req[hs_ep]);

  // R8
  a_r8_flag_on_stall: assert property (@(posedge clk) disable iff (rst)
    hs_valid && (hs_code == 2'd2) |-> stalled[hs_ep]);

  // R11
  a_r11_rsvd_silent: assert property (@(posedge clk) disable iff (rst)
    tok_valid && (tok_type == 2'd3) |=> !hs_valid);

  // R9
  a_r9_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ep_irq == (stalled & $past(stalled_ie)));

  for (genvar i = 0; i < N_EP; i++) begin : g_chk
    // R6, R7
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
      stall_clr[i] |=> !stall_req[i]);
  end
endmodule

bind ep_stall_mgr ep_stall_mgr_chk #(.N_EP(N_EP)) u_chk (
  .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_type(tok_type),
  .tok_ep(tok_ep), .ep_is_ctrl(ep_is_ctrl), .stall_set(stall_set),
  .stall_clr(stall_clr), .stalled_clr(stalled_clr), .stalled_ie(stalled_ie),
  .hs_valid(hs_valid), .hs_code(hs_code), .hs_ep(hs_ep), .rx_ok(rx_ok),
  .tx_ok(tx_ok), .stall_req(stall_req), .stalled(stalled), .ep_irq(ep_irq)
);

// File: tb/ep_stall_mgr_bench.sv
module ep_stall_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_EP = 4;
  localparam int EPW  = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic            tok_valid;
  logic [1:0]      tok_type;
  logic [EPW-1:0]  tok_ep;
  logic [N_EP-1:0] ep_is_ctrl;
  logic [N_EP-1:0] stall_set, stall_clr, stalled_clr, stalled_ie;
  logic            hs_valid, rx_ok, tx_ok;
  logic [1:0]      hs_code;
  logic [EPW-1:0]  hs_ep;
  logic [N_EP-1:0] stall_req, stalled, ep_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_stall_mgr #(.N_EP(N_EP)) u_ep_stall_mgr (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_type(tok_type),
    .tok_ep(tok_ep), .ep_is_ctrl(ep_is_ctrl), .stall_set(stall_set),
    .stall_clr(stall_clr), .stalled_clr(stalled_clr), .stalled_ie(stalled_ie),
    .hs_valid(hs_valid), .hs_code(hs_code), .hs_ep(hs_ep), .rx_ok(rx_ok),
    .tx_ok(tx_ok), .stall_req(stall_req), .stalled(stalled), .ep_irq(ep_irq)
  );

  // row: {req[3:0], ep[1:0], op[2:0], hs[1:0], rx, tx, stall_req[ep]}
  // op: 0 OUT, 1 IN, 2 SETUP, 3 reserved, 4 set, 5 clear, 6 set+clear
  localparam int NV = 17;
  localparam logic [13:0] VEC [NV] = '{
    {4'd10, 2'd1, 3'd0, 2'd1, 1'b1, 1'b0, 1'b0}, // R10 OUT ack
    {4'd10, 2'd1, 3'd1, 2'd1, 1'b0, 1'b1, 1'b0}, // R10 IN ack
    {4'd2,  2'd1, 3'd4, 2'd0, 1'b0, 1'b0, 1'b1}, // R2 arm
    {4'd3,  2'd1, 3'd0, 2'd2, 1'b0, 1'b0, 1'b1}, // R3 OUT stalled
    {4'd2,  2'd1, 3'd1, 2'd2, 1'b0, 1'b0, 1'b1}, // R2 IN stalled
    {4'd5,  2'd1, 3'd2, 2'd2, 1'b0, 1'b0, 1'b1}, // R5 SETUP non-control
    {4'd11, 2'd1, 3'd3, 2'd0, 1'b0, 1'b0, 1'b1}, // R11 reserved
    {4'd6,  2'd1, 3'd5, 2'd0, 1'b0, 1'b0, 1'b0}, // R6 clear non-control
    {4'd10, 2'd1, 3'd0, 2'd1, 1'b1, 1'b0, 1'b0}, // R10 after clear
    {4'd2,  2'd0, 3'd4, 2'd0, 1'b0, 1'b0, 1'b1}, // R2 arm control ep
    {4'd2,  2'd0, 3'd1, 2'd2, 1'b0, 1'b0, 1'b1}, // R2 IN on control
    {4'd4,  2'd0, 3'd2, 2'd1, 1'b1, 1'b0, 1'b0}, // R4 SETUP recovers
    {4'd10, 2'd0, 3'd0, 2'd1, 1'b1, 1'b0, 1'b0}, // R10
    {4'd7,  2'd2, 3'd6, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 clear wins
    {4'd10, 2'd2, 3'd2, 2'd1, 1'b1, 1'b0, 1'b0}, // R10 SETUP ack
    {4'd2,  2'd3, 3'd4, 2'd0, 1'b0, 1'b0, 1'b1}, // R2 arm ep3
    {4'd6,  2'd3, 3'd5, 2'd0, 1'b0, 1'b0, 1'b0}  // R6 clear ep3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    tok_valid = 0; tok_type = 0; tok_ep = 0;
    stall_set = 0; stall_clr = 0; stalled_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    ep_is_ctrl = 4'b0101;
    stalled_ie = 0;
    rst = 1;
    step(); step();
    rst = 0;
    step();
    // R1
    chk("R1 stall_req", 32'(stall_req), 0);
    chk("R1 stalled", 32'(stalled), 0);
    chk("R1 ep_irq", 32'(ep_irq), 0);
    chk("R1 hs_valid", 32'(hs_valid), 0);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] r;
      logic [2:0]  op;
      logic [1:0]  ep;
      string       tag;
      r   = VEC[i];
      op  = r[7:5];
      ep  = r[9:8];
      tag = $sformatf("R%0d row%0d", r[13:10], i);
      idle();
      tok_ep = ep;
      if (op < 3'd4) begin
        tok_valid = 1; tok_type = op[1:0];
      end else begin
        stall_set[ep] = (op == 3'd4) || (op == 3'd6);
        stall_clr[ep] = (op == 3'd5) || (op == 3'd6);
      end
      step();
      idle();
      chk({tag, " hs_valid"}, 32'(hs_valid), 32'(r[4:3] != 2'd0));
      chk({tag, " hs_code"}, 32'(hs_code), 32'(r[4:3]));
      chk({tag, " rx_ok"}, 32'(rx_ok), 32'(r[2]));
      chk({tag, " tx_ok"}, 32'(tx_ok), 32'(r[1]));
      chk({tag, " stall_req"}, 32'(stall_req[ep]), 32'(r[0]));
    end

    // R8: STALLs went to ep1 and ep0
    chk("R8 stalled after table", 32'(stalled), 32'h3);
    chk("R9 irq masked", 32'(ep_irq), 0);

    // R9: enable ep0 only
    stalled_ie = 4'b0001;
    step();
    chk("R9 irq enabled", 32'(ep_irq), 32'h1);
    stalled_clr[0] = 1;
    step();
    idle();
    chk("R8 w1c", 32'(stalled), 32'h2);
    chk("R9 irq after clear", 32'(ep_irq), 0);

    // R12: arm ep1 only
    stall_set[1] = 1;
    step();
    idle();
    chk("R12 isolation", 32'(stall_req), 32'h2);
    tok_valid = 1; tok_type = 2'd0; tok_ep = 2'd2;
    step();
    idle();
    chk("R12 neighbour ack", 32'(hs_code), 1);

    // R8: STALL and w1c on same endpoint, same cycle
    stalled_clr[1] = 1;
    tok_valid = 1; tok_type = 2'd1; tok_ep = 2'd1;
    step();
    idle();
    chk("R8 set beats clear", 32'(stalled[1]), 1);
    chk("R3 stall reply", 32'({hs_code, rx_ok, tx_ok}), 32'h8);

    stall_clr[1] = 1;
    step();
    idle();
    chk("R6 final clear", 32'(stall_req), 0);
    step();
    finish_run();
  end
endmodule